// File: doc/BRIEF.md
# Sum-of-Squares Memory Accelerator

This block offloads a small arithmetic job from a host CPU. The host sees a window of four 32-bit registers through an AXI4-Lite slave port. Any write into that window wakes the block. It then takes the value held in register 0 as a byte address in system memory. Through its AXI4-style master port it fetches the two words stored at that address, squares each one, adds the two squares, and stores the 32-bit result eight bytes above the address it was given.

The host places the base address in register 0. The data sit at base and base+4, and the result lands at base+8. The block signals the end of a job with a single-cycle `done` pulse, but only if memory accepts the result write. When memory reports an error on either the read or the write, the block drops the job and goes back to waiting.

Top module: `sqsum_accel`

## Requirements
- R1: A synchronous active-high reset clears all four host registers and the local buffer and returns the controller to waiting. After reset, no master valid or ready is high, `done` is low, and a host read of any register returns 0.
- R2: The block stays idle until a host write handshake completes. A host read of the window never starts a job.
- R3: When a job starts, the value in register 0 at that moment is taken as the byte address for the job.
- R4: Operands are fetched in one read burst: `m_arlen` = 1 (two beats), `m_araddr` = base, and the burst is incrementing in 4-byte steps. `m_arvalid` and `m_araddr` hold until `m_arready`. `m_rready` stays high until the beat that carries `m_rlast`.
- R5: The result is word0*word0 + word1*word1, taken modulo 2^32 with no overflow indication.
- R6: The result goes out as one write beat with `m_awaddr` = base+8, `m_awlen` = 0, `m_wstrb` = 4'b1111 and `m_wlast` = 1.
- R7: `done` pulses high for exactly one cycle. It rises in the cycle after a write response of OKAY (`m_bresp` = 2'b00) is accepted. A non-OKAY write response gives no pulse, and the block returns to idle so that the next job runs normally.
- R8: If any read beat carries a response other than 2'b00, no write is issued and the block returns to idle once the burst's last beat arrives.
- R9: Host registers sit at byte offsets 0, 4, 8 and 12, selected by address bits [3:2]. Each `s_wstrb` bit enables one byte lane. Reads return the stored value with OKAY, and `s_bvalid` holds until `s_bready`.
- R10: A write to any of the four registers starts a job, and the base address is still taken from register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 4 | Host write byte address |
| s_awvalid | input | 1 | Host write address valid |
| s_awready | output | 1 | Host write address ready |
| s_wdata | input | 32 | Host write data |
| s_wstrb | input | 4 | Host write byte enables |
| s_wvalid | input | 1 | Host write data valid |
| s_wready | output | 1 | Host write data ready |
| s_bresp | output | 2 | Host write response (always OKAY) |
| s_bvalid | output | 1 | Host write response valid |
| s_bready | input | 1 | Host write response ready |
| s_araddr | input | 4 | Host read byte address |
| s_arvalid | input | 1 | Host read address valid |
| s_arready | output | 1 | Host read address ready |
| s_rdata | output | 32 | Host read data |
| s_rresp | output | 2 | Host read response (always OKAY) |
| s_rvalid | output | 1 | Host read data valid |
| s_rready | input | 1 | Host read data ready |
| m_araddr | output | 32 | Memory read address |
| m_arlen | output | 8 | Memory read burst length minus one |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rdata | input | 32 | Memory read data |
| m_rresp | input | 2 | Memory read response |
| m_rlast | input | 1 | Memory read last beat |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_awaddr | output | 32 | Memory write address |
| m_awlen | output | 8 | Memory write burst length minus one |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_wdata | output | 32 | Memory write data |
| m_wstrb | output | 4 | Memory write byte enables |
| m_wlast | output | 1 | Memory write last beat |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_bresp | input | 2 | Memory write response |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |
| done | output | 1 | One-cycle job-complete pulse |

## Verification
Several protocol rules are checked on every cycle:
- the master never has more than one of its read-address, read-data, write and response phases active at once;
- the read address is held until it is accepted, and read-ready stays high through to the last beat;
- a job starts only after a host write has been acknowledged;
- `done` follows an accepted write response and lasts one cycle;
- the host write response is held until it is taken.

Other behaviours show up only in the bench's scenarios:
- the numeric result, including wrap past 2^32;
- the exact read and write addresses, burst fields and byte strobes;
- the byte-lane merge of partial host writes;
- the silent aborts on read and write error responses;
- the clearing effect of a reset that lands in the middle of a job.

// File: rtl/sqsum_pkg.sv
package sqsum_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic latchBase;  // capture register 0 as the job's base address
    logic capture;    // store the current read beat in the next buffer slot
    logic compute;    // form the sum of squares into the result slot
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RADDR, ST_RDATA, ST_CALC, ST_WRITE, ST_WRESP
  } ctlState_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/sqsum_regs.sv
module sqsum_regs #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 4,
  localparam int IDX_W  = $clog2(REG_CNT),
  localparam int REG_AW = IDX_W + 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [REG_AW-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              start,
  output logic [DATA_W-1:0] baseWord
);
  logic [DATA_W-1:0] regFile [REG_CNT];
  logic              wrFire;
  logic [IDX_W-1:0]  wrIdx, rdIdx;

  // Address and data are accepted together, and only once the previous response has gone
  assign wrFire   = awvalid && wvalid && !bvalid;
  assign awready  = wrFire;
  assign wready   = wrFire;
  assign arready  = !rvalid;
  assign bresp    = sqsum_pkg::RESP_OKAY;
  assign rresp    = sqsum_pkg::RESP_OKAY;
  assign wrIdx    = awaddr[REG_AW-1:2];
  assign rdIdx    = araddr[REG_AW-1:2];
  assign baseWord = regFile[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regFile[i] <= '0;
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
      start  <= 1'b0;
    end else begin
      start <= wrFire;
      if (wrFire) begin
        for (int b = 0; b < STRB_W; b++)
          if (wstrb[b]) regFile[wrIdx][b*8 +: 8] <= wdata[b*8 +: 8];
        bvalid <= 1'b1;
      end else if (bready) begin
        bvalid <= 1'b0;
      end
      if (arvalid && !rvalid) begin
        rvalid <= 1'b1;
        rdata  <= regFile[rdIdx];
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sqsum_ctrl.sv
module sqsum_ctrl
  import sqsum_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       m_arvalid,
  input  logic       m_arready,
  input  logic       m_rvalid,
  input  logic [1:0] m_rresp,
  input  logic       m_rlast,
  output logic       m_rready,
  output logic       m_awvalid,
  input  logic       m_awready,
  output logic       m_wvalid,
  input  logic       m_wready,
  input  logic       m_bvalid,
  input  logic [1:0] m_bresp,
  output logic       m_bready,
  output logic       done,
  output dpCtl_t     ctl
);
  ctlState_t state;
  logic      awSent, wSent, rdErr;
  logic      awFire, wFire;

  always_comb begin
    m_arvalid     = (state == ST_RADDR);
    m_rready      = (state == ST_RDATA);
    m_awvalid     = (state == ST_WRITE) && !awSent;
    m_wvalid      = (state == ST_WRITE) && !wSent;
    m_bready      = (state == ST_WRESP);
    awFire        = m_awvalid && m_awready;
    wFire         = m_wvalid && m_wready;
    ctl.latchBase = (state == ST_IDLE) && start;
    ctl.capture   = m_rvalid && m_rready;
    ctl.compute   = (state == ST_CALC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      awSent <= 1'b0;
      wSent  <= 1'b0;
      rdErr  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RADDR;
          rdErr <= 1'b0;
        end
        ST_RADDR: if (m_arready) state <= ST_RDATA;
        ST_RDATA: if (m_rvalid) begin
          if (m_rlast)
            state <= (rdErr || m_rresp != RESP_OKAY) ? ST_IDLE : ST_CALC;
          else
            rdErr <= rdErr || (m_rresp != RESP_OKAY);
        end
        ST_CALC: begin
          state  <= ST_WRITE;
          awSent <= 1'b0;
          wSent  <= 1'b0;
        end
        ST_WRITE: begin
          awSent <= awSent || awFire;
          wSent  <= wSent || wFire;
          if ((awSent || awFire) && (wSent || wFire)) state <= ST_WRESP;
        end
        ST_WRESP: if (m_bvalid) begin
          state <= ST_IDLE;
          done  <= (m_bresp == RESP_OKAY);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sqsum_dp.sv
module sqsum_dp
  import sqsum_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int BUF_DEPTH   = 4,
  parameter int READ_BEATS  = 2,
  parameter int RESULT_SLOT = 2,
  parameter int RESULT_OFS  = 8,
  localparam int PTR_W      = $clog2(BUF_DEPTH),
  localparam int STRB_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] baseWord,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wlast
);
  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  ptr;

  assign araddr = base;
  assign arlen  = 8'(READ_BEATS - 1);
  assign awaddr = base + ADDR_W'(RESULT_OFS);
  assign awlen  = 8'd0;
  assign wdata  = bufMem[RESULT_SLOT];
  assign wstrb  = '1;
  assign wlast  = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
      base <= '0;
      ptr  <= '0;
    end else begin
      if (ctl.latchBase) begin
        base <= ADDR_W'(baseWord);
        ptr  <= '0;
      end
      if (ctl.capture) begin
        bufMem[ptr] <= rdata;
        ptr         <= ptr + 1'b1;
      end
      if (ctl.compute)
        bufMem[RESULT_SLOT] <= bufMem[0] * bufMem[0] + bufMem[1] * bufMem[1];
    end
  end
endmodule

// File: rtl/sqsum_accel.sv
module sqsum_accel
  import sqsum_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_CNT = 4,
  localparam int REG_AW = $clog2(REG_CNT) + 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [REG_AW-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              done
);
  dpCtl_t            ctl;
  logic              start;
  logic [DATA_W-1:0] baseWord;

  sqsum_regs #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .start(start), .baseWord(baseWord)
  );

  sqsum_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rvalid(m_rvalid), .m_rresp(m_rresp), .m_rlast(m_rlast), .m_rready(m_rready),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bvalid(m_bvalid), .m_bresp(m_bresp), .m_bready(m_bready),
    .done(done), .ctl(ctl)
  );

  sqsum_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .baseWord(baseWord), .rdata(m_rdata),
    .araddr(m_araddr), .arlen(m_arlen), .awaddr(m_awaddr), .awlen(m_awlen),
    .wdata(m_wdata), .wstrb(m_wstrb), .wlast(m_wlast)
  );
endmodule

// File: rtl/sqsum_accel_chk.sv
module sqsum_accel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic              m_rlast,
  input logic              m_awvalid,
  input logic              m_wvalid,
  input logic              s_bvalid,
  input logic              s_bready
);
  p_done_after_resp_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(m_bvalid && m_bready));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ar_hold_r4: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

  p_rready_to_last_r4: assert property (@(posedge clk) disable iff (rst)
    m_rvalid && m_rready && !m_rlast |=> m_rready);

  p_phase_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m_arvalid, m_rready, m_awvalid || m_wvalid, m_bready}));

  p_start_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(m_arvalid) |-> $past(s_bvalid));

  p_bvalid_hold_r9: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid);
endmodule

bind sqsum_accel sqsum_accel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .done(done),
  .m_bvalid(m_bvalid), .m_bready(m_bready),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rlast(m_rlast),
  .m_awvalid(m_awvalid), .m_wvalid(m_wvalid),
  .s_bvalid(s_bvalid), .s_bready(s_bready)
);

// File: tb/sim_sqsum_accel.sv
`timescale 1ns / 1ps
module sim_sqsum_accel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
  logic        s_bready = 1, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;

  logic [31:0] m_araddr, m_awaddr, m_wdata;
  logic [7:0]  m_arlen, m_awlen;
  logic        m_arvalid, m_rready, m_awvalid, m_wvalid, m_wlast, m_bready, done;
  logic [3:0]  m_wstrb;
  logic        m_arready = 0, m_rvalid = 0, m_rlast = 0, m_awready = 0, m_wready = 0, m_bvalid = 0;
  logic [31:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0, m_bresp = '0;

  sqsum_accel u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // memory model state
  logic [31:0] mem [64];
  logic [1:0]  rdResp = 2'b00, wrResp = 2'b00;
  logic [31:0] lastAraddr, lastAwaddr;
  logic [7:0]  lastArlen, lastAwlen;
  logic [3:0]  lastWstrb;
  logic        lastWlast;
  int          readCount = 0, writeCount = 0;

  // {base, word0, word1}
  localparam logic [95:0] VECS [5] = '{
    {32'h0000_0000, 32'd3,          32'd4},
    {32'h0000_0040, 32'd0,          32'd0},
    {32'h0000_0080, 32'h0000_FFFF,  32'h0000_FFFF},
    {32'h0000_0020, 32'h8000_0000,  32'd1},
    {32'h0000_00E0, 32'd1234,       32'd56789}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] addr, input logic [31:0] data, input logic [3:0] strb);
    @(negedge clk);
    s_awaddr = addr; s_wdata = data; s_wstrb = strb; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
  endtask

  task automatic hostRead(input logic [3:0] addr, output logic [31:0] data);
    @(negedge clk);
    s_araddr = addr; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0;
    data = s_rdata;
  endtask

  // watch for `cycles` cycles, counting cycles in which done is high
  task automatic watchDone(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
  endtask

  // memory responder, driven on falling edges
  initial begin : memModel
    logic [31:0] capAddr;
    logic [7:0]  capLen;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (m_arvalid) begin
        capAddr = m_araddr; capLen = m_arlen;
        lastAraddr = m_araddr; lastArlen = m_arlen; readCount++;
        m_arready = 1;
        @(negedge clk);
        m_arready = 0;
        for (int b = 0; b <= int'(capLen); b++) begin
          m_rvalid = 1; m_rresp = rdResp;
          m_rdata  = mem[(capAddr[7:2] + 6'(b))];
          m_rlast  = (b == int'(capLen));
          @(negedge clk);
        end
        m_rvalid = 0; m_rlast = 0;
      end else if (m_awvalid && m_wvalid) begin
        lastAwaddr = m_awaddr; lastAwlen = m_awlen;
        lastWstrb = m_wstrb; lastWlast = m_wlast; writeCount++;
        for (int b = 0; b < 4; b++)
          if (m_wstrb[b]) mem[m_awaddr[7:2]][b*8 +: 8] = m_wdata[b*8 +: 8];
        m_awready = 1; m_wready = 1;
        @(negedge clk);
        m_awready = 0; m_wready = 0;
        m_bvalid = 1; m_bresp = wrResp;
        @(negedge clk);
        m_bvalid = 0;
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd, b, w0, w1, exp;
    int pulses, wc;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 arvalid", {31'd0, m_arvalid}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    for (int r = 0; r < 4; r++) begin
      hostRead(4'(r * 4), rd);
      check("R1 reg clear", rd, 32'd0);
    end

    // R2: reads never start a job
    repeat (10) @(negedge clk);
    check("R2 no read burst after host reads", readCount, 32'd0);

    // R5/R3/R4/R6/R7: vector table
    foreach (VECS[v]) begin
      {b, w0, w1} = VECS[v];
      exp = w0 * w0 + w1 * w1;
      mem[b[7:2]] = w0; mem[b[7:2] + 1] = w1;
      hostWrite(4'h0, b, 4'hF);
      watchDone(40, pulses);
      check("R5 result", mem[b[7:2] + 2], exp);
      check("R3 base address", lastAraddr, b);
      check("R4 arlen", {24'd0, lastArlen}, 32'd1);
      check("R6 awaddr", lastAwaddr, b + 32'd8);
      check("R6 awlen/wlast/wstrb", {lastAwlen, 19'd0, lastWlast, lastWstrb}, {8'd0, 19'd0, 1'b1, 4'hF});
      check("R7 done pulse width", pulses, 32'd1);
    end

    // R9: byte-lane writes to reg1 (address 4), each write also starts a job (R10)
    hostWrite(4'h4, 32'hAABBCCDD, 4'hF);
    watchDone(40, pulses);
    hostWrite(4'h4, 32'h11223344, 4'b0010);
    watchDone(40, pulses);
    hostRead(4'h4, rd);
    check("R9 byte-lane merge", rd, 32'hAABB33DD);
    check("R9 read response", {30'd0, s_rresp}, 32'd0);

    // R10: write to reg3 starts a job using reg0 (0xE0)
    mem[56] = 32'd7; mem[57] = 32'd9;
    hostWrite(4'hC, 32'h0000_0010, 4'hF);
    watchDone(40, pulses);
    check("R10 base still reg0", lastAraddr, 32'h0000_00E0);
    check("R10 result", mem[58], 32'd130);
    check("R10 done", pulses, 32'd1);

    // R8: read error -> no write
    wc = writeCount;
    rdResp = 2'b10;
    hostWrite(4'h0, 32'h0000_0060, 4'hF);
    watchDone(40, pulses);
    rdResp = 2'b00;
    check("R8 no write after read error", writeCount, wc);
    check("R8 no done after read error", pulses, 32'd0);

    // R7: write error -> no done, then a normal job works
    wrResp = 2'b10;
    mem[24] = 32'd5; mem[25] = 32'd12;
    hostWrite(4'h0, 32'h0000_0060, 4'hF);
    watchDone(40, pulses);
    wrResp = 2'b00;
    check("R7 no done on write error", pulses, 32'd0);
    mem[24] = 32'd6; mem[25] = 32'd8;
    hostWrite(4'h0, 32'h0000_0060, 4'hF);
    watchDone(40, pulses);
    check("R7 recovery done", pulses, 32'd1);
    check("R7 recovery result", mem[26], 32'd100);

    // R1: reset in the middle of a job
    hostWrite(4'h0, 32'h0000_0040, 4'hF);
    repeat (2) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1 master idle after reset", {28'd0, m_arvalid, m_rready, m_awvalid, m_bready}, 32'd0);
    repeat (10) @(negedge clk);
    hostRead(4'h0, rd);
    check("R1 reg0 cleared", rd, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule